// File: doc/BRIEF.md
# DSI command packet register interface

This block is the command path that sits behind the register file of a DSI host controller. For transmission, software first writes the payload words of a packet into a transmit word FIFO. It then writes the packet header. That header write is what starts the packet. The block sends the three header bytes and then the payload bytes over a byte-wide valid/ready stream toward the link layer. Low-power or high-speed signalling is chosen per packet by one header bit. While a packet is in flight, a busy flag and a FIFO-occupancy flag are held, and software polls them before it queues the next packet.

For reception, the link layer hands a returned packet to the block one byte at a time. The block rebuilds the 24-bit header and decides from the data type whether the packet is short or long. For a long packet it packs the payload bytes four to a word into a receive FIFO. A read-data-available flag tells software that a header is waiting. Software reads the header register and then drains the payload register. ECC, checksum, lane striping and the PHY are outside this block.

Register map, as word addresses on `wr_addr`/`rd_addr`:
- 0: status (read only). Bit 16 is busy, bit 17 is transmit FIFO not empty, bit 18 is read data available, bit 19 is header-rejected error. All other bits read as zero.
- 1: transmit header (write only).
- 2: transmit payload (write only).
- 3: receive header (read only).
- 4: receive payload (read only).

Header layout, used for both directions:
- Bits 5:0: data type. Values 0x00 to 0x0F are short packets; every other value is a long packet.
- Bits 7:0: the first byte sent or received.
- Bits 15:8 and 23:16: the next two bytes. For a long packet these two bytes together form the word count, held in bits 23:8.
- Bit 24 (transmit only): set for low-power, clear for high-speed.

Top module: `dsi_cmd_regif`

## Requirements
- R1: After reset the status register reads zero, `tx_valid` is low and `rx_ready` is high.
- R2: An accepted write to the transmit header register starts a packet whose first three stream bytes are header bits 7:0, then 15:8, then 23:16.
- R3: A short packet (data type below 0x10), or a long packet with word count zero, sends exactly the three header bytes. `tx_last` is set on the third byte, and any queued payload words stay in the FIFO (status bit 17 stays set).
- R4: A long packet with a non-zero word count N sends exactly N payload bytes after the header. They are taken little-endian from successive FIFO words (bits 7:0 first). The padding of the final word is discarded, and `tx_last` marks the Nth byte.
- R5: `tx_lp` equals bit 24 of the launching header on every byte of the packet.
- R6: Status bit 16 (busy) and bit 17 (FIFO not empty, while that packet's words remain) stay set from the accepted header write until the last byte has been transferred. Busy clears in the following cycle.
- R7: A header write while busy is not accepted and sets status bit 19. The next accepted header write clears it.
- R8: A payload write into a full transmit FIFO (TX_DEPTH words) is dropped, and that word is never sent.
- R9: The first three accepted receive bytes form the receive header (first byte in bits 7:0). Status bit 18 is set in the cycle after the third byte.
- R10: Long-packet receive payload bytes are packed little-endian into words read from address 4, and the final partial word is zero-padded.
- R11: Status bit 18 clears only once the header register has been read and every payload word of that packet has been read. Until then `rx_ready` stays low for a new header, and it is also low while the receive FIFO is full during a payload.
- R12: Reading the receive payload register while the receive FIFO is empty returns zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (pops and clears act on it) |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | 32 | Register read data, combinational on `rd_addr` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Link layer accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_lp | output | 1 | Packet uses low-power transmission |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts the receive byte |
| rx_data | input | 8 | Receive byte |

## Verification
The bench chases the byte boundaries of long packets: word counts that end mid-word, word count zero, and a FIFO that was overfilled. A design that mis-handles these would send padding bytes, drop or repeat a byte, or send a word that should have been dropped. It writes a header in the very cycle after a launch to check rejection. A wrong design would corrupt the packet in flight or leave the error flag clear. On the receive side it holds a new packet while the previous header is still unread, and fills the receive FIFO mid-payload. A wrong design would overwrite the pending header, push into a full FIFO, or clear read-data-available early. It also reads the receive payload register when empty; a faulty design would return stale data.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;
   localparam int WORD_W   = 32;
   localparam int HDR_W    = 25;
   localparam int LP_BIT   = 24;
   localparam int ST_BUSY  = 16;
   localparam int ST_FIFO  = 17;
   localparam int ST_AVAIL = 18;
   localparam int ST_ERR   = 19;
   localparam int ADR_STATUS = 0;
   localparam int ADR_TX_HDR = 1;
   localparam int ADR_TX_PLD = 2;
   localparam int ADR_RX_HDR = 3;
   localparam int ADR_RX_PLD = 4;

   // data types 0x00..0x0F are short, the rest long
   function automatic logic is_long(input logic [5:0] dt);
      return dt >= 6'h10;
   endfunction
endpackage

// File: rtl/dsi_cmd_fifo.sv
module dsi_cmd_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("dsi_cmd_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         if (do_push && !do_pop)      cnt <= cnt + (AW+1)'(1);
         else if (do_pop && !do_push) cnt <= cnt - (AW+1)'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   // R8: a push into a full FIFO leaves it full, nothing is lost from it
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   // R12: popping an empty FIFO leaves it empty
   p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
   import dsi_cmd_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_wr,
   input  logic [HDR_W-1:0] hdr_in,
   input  logic [W-1:0]     pld_word,
   input  logic             pld_empty,
   output logic             pld_pop,
   output logic             busy,
   output logic             err,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [7:0]       tx_data,
   output logic             tx_lp,
   output logic             tx_last
);
   localparam int BPW = W / 8;
   localparam int BW  = (BPW > 1) ? $clog2(BPW) : 1;

   generate
      if (W % 8 != 0 || (1 << BW) != BPW) begin : g_bad_width
         $error("dsi_cmd_tx: word width must hold a power-of-two byte count");
      end
   endgenerate

   typedef enum logic [1:0] {T_IDLE, T_HDR, T_PLD} tx_st_e;

   tx_st_e           st;
   logic [HDR_W-1:0] hdr_q;
   logic [1:0]       hb;
   logic [15:0]      rem;
   logic [BW-1:0]    lane;
   logic             has_pld, fire;
   logic [7:0]       hdr_byte, pld_byte;

   assign has_pld  = is_long(hdr_q[5:0]) && (hdr_q[23:8] != 16'd0);
   assign hdr_byte = hdr_q[{hb, 3'b000} +: 8];
   assign pld_byte = pld_word[{lane, 3'b000} +: 8];

   assign busy     = (st != T_IDLE);
   assign tx_valid = (st == T_HDR) || (st == T_PLD && !pld_empty);
   assign tx_data  = (st == T_PLD) ? pld_byte : hdr_byte;
   assign tx_lp    = hdr_q[LP_BIT];
   assign tx_last  = (st == T_HDR && hb == 2'd2 && !has_pld) ||
                     (st == T_PLD && rem == 16'd1);
   assign fire     = tx_valid && tx_ready;
   assign pld_pop  = fire && (st == T_PLD) &&
                     (lane == BW'(BPW-1) || rem == 16'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= T_IDLE;
         hdr_q <= '0;
         hb    <= '0;
         rem   <= '0;
         lane  <= '0;
         err   <= 1'b0;
      end else begin
         if (hdr_wr) begin
            if (st == T_IDLE) begin
               st    <= T_HDR;
               hdr_q <= hdr_in;
               hb    <= '0;
               err   <= 1'b0;
            end else begin
               err <= 1'b1;
            end
         end
         if (fire) begin
            case (st)
               T_HDR: begin
                  if (hb == 2'd2) begin
                     if (has_pld) begin
                        st   <= T_PLD;
                        rem  <= hdr_q[23:8];
                        lane <= '0;
                     end else begin
                        st <= T_IDLE;
                     end
                  end else begin
                     hb <= hb + 2'd1;
                  end
               end
               T_PLD: begin
                  rem  <= rem - 16'd1;
                  lane <= lane + BW'(1);
                  if (rem == 16'd1) st <= T_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   // R2: an offered byte holds until it is taken
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
   // R6: busy drops right after the final byte
   p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !busy);
   // R7: header write while busy raises the error flag
   p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_wr && busy) |=> err);
endmodule

// File: rtl/dsi_cmd_rx.sv
module dsi_cmd_rx
   import dsi_cmd_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   output logic         rx_ready,
   input  logic [7:0]   rx_data,
   output logic [23:0]  hdr_q,
   output logic         push,
   output logic [W-1:0] push_word,
   input  logic         fifo_full,
   input  logic         pop,
   input  logic         hdr_read,
   output logic         rd_avail
);
   localparam int BPW  = W / 8;
   localparam int BW   = (BPW > 1) ? $clog2(BPW) : 1;
   localparam int WL_W = 17 - BW;

   typedef enum logic {R_HDR, R_PLD} rx_st_e;

   rx_st_e          st;
   logic [1:0]      hb;
   logic [15:0]     rem;
   logic [BW-1:0]   lane;
   logic [W-1:0]    acc, merged;
   logic            pend, fire, hdr_done;
   logic [WL_W-1:0] wleft;
   logic [15:0]     new_wc;

   assign rd_avail  = pend || (wleft != '0);
   assign rx_ready  = (st == R_HDR && !rd_avail) || (st == R_PLD && !fifo_full);
   assign fire      = rx_valid && rx_ready;
   assign hdr_done  = fire && (st == R_HDR) && (hb == 2'd2);
   assign new_wc    = {rx_data, hdr_q[15:8]};
   assign merged    = acc | (W'(rx_data) << {lane, 3'b000});
   assign push      = fire && (st == R_PLD) && (lane == BW'(BPW-1) || rem == 16'd1);
   assign push_word = merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= R_HDR;
         hb    <= '0;
         hdr_q <= '0;
         rem   <= '0;
         lane  <= '0;
         acc   <= '0;
         pend  <= 1'b0;
         wleft <= '0;
      end else begin
         if (hdr_read) pend <= 1'b0;
         if (pop && wleft != '0) wleft <= wleft - WL_W'(1);
         if (fire) begin
            if (st == R_HDR) begin
               hdr_q[{hb, 3'b000} +: 8] <= rx_data;
               if (hb == 2'd2) begin
                  hb   <= '0;
                  pend <= 1'b1;
                  if (is_long(hdr_q[5:0]) && new_wc != 16'd0) begin
                     st    <= R_PLD;
                     rem   <= new_wc;
                     lane  <= '0;
                     acc   <= '0;
                     wleft <= WL_W'((17'(new_wc) + 17'(BPW-1)) >> BW);
                  end
               end else begin
                  hb <= hb + 2'd1;
               end
            end else begin
               rem  <= rem - 16'd1;
               lane <= lane + BW'(1);
               acc  <= push ? '0 : merged;
               if (rem == 16'd1) st <= R_HDR;
            end
         end
      end
   end

   // R9: a completed header makes read data available
   p_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done |=> rd_avail);
   // R11: availability falls only after a header read or a payload pop
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_avail && !hdr_read && !pop) |=> rd_avail);
endmodule

// File: rtl/dsi_cmd_regif.sv
module dsi_cmd_regif
   import dsi_cmd_pkg::*;
#(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 4,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_lp,
   output logic              tx_last,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [7:0]        rx_data
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("dsi_cmd_regif: ADDR_W must cover five registers");
      end
   endgenerate

   logic              hdr_wr, pld_wr, hdr_rd, pld_rd;
   logic              txf_pop, txf_empty, txf_full;
   logic [WORD_W-1:0] txf_word;
   logic              busy, err;
   logic              rxf_push, rxf_pop, rxf_empty, rxf_full;
   logic [WORD_W-1:0] rxf_din, rxf_word;
   logic [23:0]       rx_hdr;
   logic              rd_avail;

   assign hdr_wr  = wr_en && (wr_addr == ADDR_W'(ADR_TX_HDR));
   assign pld_wr  = wr_en && (wr_addr == ADDR_W'(ADR_TX_PLD));
   assign hdr_rd  = rd_en && (rd_addr == ADDR_W'(ADR_RX_HDR));
   assign pld_rd  = rd_en && (rd_addr == ADDR_W'(ADR_RX_PLD));
   assign rxf_pop = pld_rd && !rxf_empty;

   dsi_cmd_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .push(pld_wr), .din(wr_data),
      .pop(txf_pop), .dout(txf_word), .empty(txf_empty), .full(txf_full));

   dsi_cmd_tx #(.W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_in(wr_data[HDR_W-1:0]),
      .pld_word(txf_word), .pld_empty(txf_empty), .pld_pop(txf_pop),
      .busy(busy), .err(err), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_lp(tx_lp), .tx_last(tx_last));

   dsi_cmd_rx #(.W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .rx_data(rx_data), .hdr_q(rx_hdr), .push(rxf_push), .push_word(rxf_din),
      .fifo_full(rxf_full), .pop(rxf_pop), .hdr_read(hdr_rd), .rd_avail(rd_avail));

   dsi_cmd_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .push(rxf_push), .din(rxf_din),
      .pop(rxf_pop), .dout(rxf_word), .empty(rxf_empty), .full(rxf_full));

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADR_STATUS)) begin
         rd_data[ST_BUSY]  = busy;
         rd_data[ST_FIFO]  = !txf_empty;
         rd_data[ST_AVAIL] = rd_avail;
         rd_data[ST_ERR]   = err;
      end else if (rd_addr == ADDR_W'(ADR_RX_HDR)) begin
         rd_data = {8'h00, rx_hdr};
      end else if (rd_addr == ADDR_W'(ADR_RX_PLD)) begin
         rd_data = rxf_empty ? '0 : rxf_word;
      end
   end

   // R3: the transmit FIFO is never popped while the packet path is idle
   p_idle_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !txf_pop);
   // R11: the receive FIFO is never pushed while full
   p_rx_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_full |-> !rxf_push);
endmodule

// File: tb/dsi_cmd_regif_bench.sv
module dsi_cmd_regif_bench;
   import dsi_cmd_pkg::*;

   localparam int TXD = 8;
   localparam int RXD = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        tx_valid, tx_ready = 1'b1, tx_lp, tx_last;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0, rx_ready;
   logic [7:0]  rx_data = '0;

   int n_cmp = 0, n_bad = 0;

   always #4 clk = ~clk;

   dsi_cmd_regif #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(3)) u_dsi_cmd_regif (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_lp(tx_lp),
      .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   bit          m_busy, m_err;
   logic [11:0] exp_q[$];      // {is_pld, lp, last, byte} (bit 11 unused)
   logic [31:0] m_txf[$];
   int          m_rph, m_rhb, m_rrem, m_rlane, m_wleft;
   logic [23:0] m_rhdr;
   logic [31:0] m_racc;
   bit          m_pend;
   logic [31:0] m_rxq[$];

   always @(negedge clk) begin
      bit          busy_now, avail, exp_rdy, lng;
      logic [11:0] e;
      logic [24:0] h;
      logic [31:0] w;
      int          wc;
      if (!rst_n) begin
         m_busy = 0; m_err = 0; exp_q.delete(); m_txf.delete();
         m_rph = 0; m_rhb = 0; m_rrem = 0; m_rlane = 0; m_wleft = 0;
         m_rhdr = '0; m_racc = '0; m_pend = 0; m_rxq.delete();
      end else begin
         avail   = m_pend || (m_wleft != 0);
         exp_rdy = (m_rph == 0 && !avail) || (m_rph == 1 && m_rxq.size() < RXD);
         if (rd_addr == 3'(ADR_STATUS)) begin
            chk(rd_data[ST_BUSY] == m_busy, "R6 busy", 32'(rd_data[ST_BUSY]), 32'(m_busy));
            chk(rd_data[ST_ERR] == m_err, "R7 err", 32'(rd_data[ST_ERR]), 32'(m_err));
            chk(rd_data[ST_AVAIL] == avail, "R11 avail", 32'(rd_data[ST_AVAIL]), 32'(avail));
         end
         chk(rx_ready == exp_rdy, "R11 rx_ready", 32'(rx_ready), 32'(exp_rdy));
         if (tx_valid && !m_busy)
            chk(0, "R2 unexpected tx_valid", 32'(tx_valid), 32'd0);
         if (rd_en && rd_addr == 3'(ADR_RX_HDR))
            chk(rd_data == {8'h0, m_rhdr}, "R9 rx header", rd_data, {8'h0, m_rhdr});
         if (rd_en && rd_addr == 3'(ADR_RX_PLD)) begin
            if (m_rxq.size() > 0)
               chk(rd_data == m_rxq[0], "R10 rx payload", rd_data, m_rxq[0]);
            else
               chk(rd_data == 32'd0, "R12 empty read", rd_data, 32'd0);
         end
         // transmit side
         busy_now = m_busy;
         if (tx_valid && tx_ready && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(tx_data == e[7:0], e[10] ? "R4 payload byte" : "R2 header byte",
                32'(tx_data), 32'(e[7:0]));
            chk(tx_lp == e[9], "R5 lp", 32'(tx_lp), 32'(e[9]));
            chk(tx_last == e[8], e[10] ? "R4 last" : "R3 last", 32'(tx_last), 32'(e[8]));
            if (exp_q.size() == 0) m_busy = 0;
         end
         if (wr_en && wr_addr == 3'(ADR_TX_PLD) && m_txf.size() < TXD)
            m_txf.push_back(wr_data);
         if (wr_en && wr_addr == 3'(ADR_TX_HDR)) begin
            if (busy_now) m_err = 1;
            else begin
               h = wr_data[24:0];
               wc = int'(h[23:8]);
               lng = (h[5:0] >= 6'h10) && (wc != 0);
               m_err = 0; m_busy = 1;
               exp_q.push_back({2'b00, h[24], 1'b0, h[7:0]});
               exp_q.push_back({2'b00, h[24], 1'b0, h[15:8]});
               exp_q.push_back({2'b00, h[24], !lng, h[23:16]});
               if (lng) begin
                  w = '0;
                  for (int i = 0; i < wc; i++) begin
                     if (i % 4 == 0) w = (m_txf.size() > 0) ? m_txf.pop_front() : 32'hDEADBEEF;
                     exp_q.push_back({2'b01, h[24], (i == wc - 1), w[8*(i%4) +: 8]});
                  end
               end
            end
         end
         // receive side
         if (rd_en && rd_addr == 3'(ADR_RX_HDR)) m_pend = 0;
         if (rd_en && rd_addr == 3'(ADR_RX_PLD) && m_rxq.size() > 0) begin
            void'(m_rxq.pop_front());
            if (m_wleft > 0) m_wleft--;
         end
         if (rx_valid && rx_ready) begin
            if (m_rph == 0) begin
               m_rhdr[8*m_rhb +: 8] = rx_data;
               if (m_rhb == 2) begin
                  m_rhb = 0; m_pend = 1;
                  wc = int'(m_rhdr[23:8]);
                  if (m_rhdr[5:0] >= 6'h10 && wc != 0) begin
                     m_rph = 1; m_rrem = wc; m_rlane = 0; m_racc = '0;
                     m_wleft = (wc + 3) / 4;
                  end
               end else m_rhb++;
            end else begin
               m_racc[8*m_rlane +: 8] = rx_data;
               if (m_rlane == 3 || m_rrem == 1) begin
                  m_rxq.push_back(m_racc); m_racc = '0; m_rlane = 0;
               end else m_rlane++;
               m_rrem--;
               if (m_rrem == 0) m_rph = 0;
            end
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1; wr_addr = 3'(a); wr_data = d;
      cyc();
      wr_en = 0; wr_addr = '0;
   endtask

   task automatic rd(input int a);
      rd_en = 1; rd_addr = 3'(a);
      cyc();
      rd_en = 0; rd_addr = 3'(ADR_STATUS);
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (m_busy && guard < 500) begin cyc(); guard++; end
      cyc();
   endtask

   task automatic rx_send(input logic [7:0] b);
      rx_valid = 1; rx_data = b;
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      @(posedge clk); #1;
      rx_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(rd_data == 32'd0, "R1 status", rd_data, 32'd0);
      chk(tx_valid == 1'b0, "R1 tx_valid", 32'(tx_valid), 32'd0);
      chk(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 32'd1);
      cyc();

      // R2/R3: short high-speed packet
      wr(ADR_TX_HDR, 32'h0034_1205);
      wait_idle();

      // R3/R5: short low-power packet with a word queued, word stays
      wr(ADR_TX_PLD, 32'h4433_2211);
      wr(ADR_TX_HDR, 32'h0100_A703);
      wait_idle();
      @(negedge clk);
      chk(rd_data[ST_FIFO] == 1'b1, "R3 fifo kept", 32'(rd_data[ST_FIFO]), 32'd1);
      cyc();

      // R4/R6: long packet wc=6 consuming the kept word and one more
      wr(ADR_TX_PLD, 32'h8877_6655);
      wr(ADR_TX_HDR, 32'h0000_0639);
      @(negedge clk);
      chk(rd_data[ST_FIFO] == 1'b1, "R6 fifo during packet", 32'(rd_data[ST_FIFO]), 32'd1);
      wait_idle();
      @(negedge clk);
      chk(rd_data[ST_FIFO] == 1'b0, "R6 fifo drained", 32'(rd_data[ST_FIFO]), 32'd0);
      cyc();

      // R4/R5: long low-power wc=9 with backpressure
      wr(ADR_TX_PLD, 32'h0302_0100);
      wr(ADR_TX_PLD, 32'h0706_0504);
      wr(ADR_TX_PLD, 32'hFFFF_FF08);
      wr(ADR_TX_HDR, 32'h0100_0929);
      while (m_busy) begin tx_ready = ~tx_ready; cyc(); end
      tx_ready = 1; cyc();

      // R7: header write while busy is rejected, next accepted clears error
      wr(ADR_TX_PLD, 32'hCAFE_BABE);
      wr(ADR_TX_PLD, 32'h1234_5678);
      wr(ADR_TX_HDR, 32'h0000_0829);
      wr(ADR_TX_HDR, 32'h0000_0105);
      wait_idle();
      @(negedge clk);
      chk(rd_data[ST_ERR] == 1'b1, "R7 err set", 32'(rd_data[ST_ERR]), 32'd1);
      cyc();
      wr(ADR_TX_HDR, 32'h0000_0029);   // long, word count zero
      wait_idle();

      // R8: overfill the transmit FIFO, extra words dropped
      for (int i = 0; i < TXD + 2; i++) wr(ADR_TX_PLD, 32'hA000_0000 + 32'(i * 32'h0101_0101));
      wr(ADR_TX_HDR, 32'(((4 * TXD) << 8) | 8'h39));
      wait_idle();
      @(negedge clk);
      chk(rd_data[ST_FIFO] == 1'b0, "R8 dropped words not queued", 32'(rd_data[ST_FIFO]), 32'd0);
      cyc();

      // R9/R11: short receive, next packet held until header read
      rx_send(8'h02); rx_send(8'hAB); rx_send(8'hCD);
      rx_valid = 1; rx_data = 8'h1A;
      repeat (3) cyc();
      rd(ADR_RX_HDR);
      rx_send(8'h1A); rx_send(8'h05); rx_send(8'h00);
      for (int i = 0; i < 5; i++) rx_send(8'h11 + 8'(i));
      rd(ADR_RX_PLD);
      rd(ADR_RX_PLD);
      rd(ADR_RX_HDR);
      rd(ADR_RX_PLD);               // R12: empty read returns zero
      cyc();

      // R10/R11: long receive overfilling the receive FIFO
      rx_send(8'h39); rx_send(8'd18); rx_send(8'h00);
      for (int i = 0; i < 16; i++) rx_send(8'h20 + 8'(i));
      rx_valid = 1; rx_data = 8'h30;
      repeat (2) cyc();
      rd(ADR_RX_PLD);
      rx_send(8'h30); rx_send(8'h31);
      for (int i = 0; i < 4; i++) rd(ADR_RX_PLD);
      rd(ADR_RX_HDR);
      rd(ADR_RX_PLD);
      repeat (3) cyc();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule